// File: doc/BRIEF.md
# Interrupt Level CSR Extension

This block holds the control and status registers that a hart needs when its interrupts are handled by level. The registers are the vector-table base, the interrupt threshold, the read-only active-level status and the extended fields of the cause register. The hart's CSR unit issues one read or one write per cycle, each with a 12-bit CSR address. The block returns read data combinationally and raises an illegal flag when the address is not one it implements. Address bits 9:8 pick the privilege copy. A machine copy is always present. A user copy is present when `USER_EN` is set.

Each copy tracks two interrupt levels. The active level is the level of the handler that is running now. The previous level is the level that was active before the most recent interrupt entry. The hart's trap logic reports interrupt entry and return on strobe inputs, and the block moves the levels on those strobes. The cause register's layout depends on the low two bits of the trap vector register, which come in on `tvec_mode_i`. When those bits equal 3, controller mode is on, and the cause register also carries the previous level, a previous-enable bit and, for the machine copy, a previous-privilege field. The previous-enable and previous-privilege values are exported to the hart's status logic.

Top module: `irq_lvl_csr`

## Requirements
- R1: A write to a vector-table base register (machine 0x307, user 0x007) stores the write data with bits 5:0 forced to zero, so every read shows bits 5:0 as zero.
- R2: The status registers (machine 0xFB1, user 0xCB1) ignore writes. A read returns the user active level in bits 7:0. The machine copy also returns the machine active level in bits 31:24. All other bits read zero.
- R3: After reset, the threshold, active level and previous level of each copy all hold 0x0F, which is all ones over CTL_BITS=4 bits. The vector base, cause fields, previous-enable and previous-privilege are zero.
- R4: A write to a threshold register (machine 0x347, user 0x047) stores write bits 7:0 OR 0x0F. A read returns that value in bits 7:0.
- R5: When tvec_mode_i is not 3, a cause read (machine 0x342, user 0x042) returns only the interrupt flag in bit 31 and the exception code in bits 4:0 (CODE_W=5). A cause write then updates only those two fields.
- R6: When tvec_mode_i is 3, a cause read also returns the previous level in bits 23:16 and previous-enable in bit 27. The machine copy also returns previous-privilege in bits 29:28. A cause write stores all of these fields from the same bit positions.
- R7: When a cause write sets the previous level in controller mode, the stored value has its low 8-CTL_BITS bits forced to one, which means OR 0x0F.
- R8: Address bits 9:8 equal to 3 select the machine copy and 0 selects the user copy. Any other address, including user addresses when USER_EN=0, raises csr_illegal_o when it is strobed, reads zero, and changes no state.
- R9: On lvl_enter_i, the selected copy (user when lvl_user_i=1) copies its active level into its previous level and takes lvl_new_i OR 0x0F as its new active level. On lvl_exit_i without lvl_enter_i, the active level takes the previous level.
- R10: If lvl_enter_i and a controller-mode cause write to the same copy fall in one cycle, the previous level takes the old active level. The previous-enable and previous-privilege bits still take the written values.
- R11: mpie_o, mpp_o and upie_o always show the stored previous-enable and previous-privilege values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_re_i | input | 1 | CSR read strobe |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data, combinational |
| csr_illegal_o | output | 1 | Strobed address is not implemented |
| tvec_mode_i | input | 2 | Low two bits of the trap vector register |
| lvl_enter_i | input | 1 | Interrupt entry strobe |
| lvl_exit_i | input | 1 | Interrupt return strobe |
| lvl_user_i | input | 1 | Entry or return concerns the user copy |
| lvl_new_i | input | 8 | Level of the interrupt being entered |
| mpie_o | output | 1 | Machine previous-enable |
| mpp_o | output | 2 | Machine previous-privilege |
| upie_o | output | 1 | User previous-enable |

## Verification
Two events can both try to change the previous level in the same cycle: an interrupt entry and a controller-mode cause write. The bench provokes this in two ways. A directed step asserts the entry strobe and the cause write together. A long pseudo-random run drives entries, returns, CSR accesses and changes of the vector mode independently, so these events overlap many times. The behavioural reference model saves the old active level before it applies any write. A cause read in a later cycle shows whether the previous level took the old active level or the written value, and the exported enable and privilege bits show whether the written values still landed.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  localparam int DW = 32;

  typedef enum logic [2:0] {
    FN_NONE,
    FN_TVT,
    FN_CAUSE,
    FN_THR,
    FN_STAT
  } fn_e;

  typedef struct packed {
    fn_e  fn;
    logic mcopy;
  } dec_t;
endpackage

// File: rtl/irq_lvl_dec.sv
module irq_lvl_dec
  import irq_lvl_pkg::*;
#(
  parameter bit USER_EN = 1'b1
) (
  input  logic [11:0] addr_i,
  output dec_t        dec_o
);
  logic [9:0] key;
  logic       copy_ok;

  assign key     = {addr_i[11:10], addr_i[7:0]};
  assign copy_ok = (addr_i[9:8] == 2'b11) || ((addr_i[9:8] == 2'b00) && USER_EN);

  always_comb begin
    dec_o.mcopy = (addr_i[9:8] == 2'b11);
    dec_o.fn    = FN_NONE;
    if (copy_ok) begin
      case (key)
        10'h007: dec_o.fn = FN_TVT;
        10'h042: dec_o.fn = FN_CAUSE;
        10'h047: dec_o.fn = FN_THR;
        10'h3B1: dec_o.fn = FN_STAT;
        default: dec_o.fn = FN_NONE;
      endcase
    end
  end
endmodule

// File: rtl/irq_lvl_bank.sv
module irq_lvl_bank #(
  parameter int CTL_BITS = 4,
  parameter int CODE_W   = 5,
  parameter bit HAS_PP   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clic_i,
  input  logic              wr_tvt_i,
  input  logic              wr_cause_i,
  input  logic              wr_thr_i,
  input  logic [31:0]       wdata_i,
  input  logic              enter_i,
  input  logic              exit_i,
  input  logic [7:0]        enter_lvl_i,
  output logic [31:0]       tvt_o,
  output logic [7:0]        thr_o,
  output logic [7:0]        act_o,
  output logic [7:0]        plvl_o,
  output logic              pie_o,
  output logic [1:0]        pp_o,
  output logic              intr_o,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [7:0] THR_ONES = 8'((1 << CTL_BITS) - 1);
  localparam logic [7:0] PL_ONES  = 8'((1 << (8 - CTL_BITS)) - 1);

  logic [31:6]       tvt_q;
  logic [7:0]        thr_q, act_q, plvl_q;
  logic              pie_q, intr_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tvt_q  <= '0;
      thr_q  <= THR_ONES;
      act_q  <= THR_ONES;
      plvl_q <= THR_ONES;
      pie_q  <= 1'b0;
      intr_q <= 1'b0;
      code_q <= '0;
    end else begin
      if (wr_tvt_i) tvt_q <= wdata_i[31:6];
      if (wr_thr_i) thr_q <= wdata_i[7:0] | THR_ONES;
      if (wr_cause_i) begin
        intr_q <= wdata_i[31];
        code_q <= wdata_i[CODE_W-1:0];
        if (clic_i) pie_q <= wdata_i[27];
      end
      // entry owns the previous level over a same-cycle cause write
      if (enter_i) begin
        plvl_q <= act_q;
        act_q  <= enter_lvl_i | PL_ONES;
      end else begin
        if (wr_cause_i && clic_i) plvl_q <= wdata_i[23:16] | PL_ONES;
        if (exit_i) act_q <= plvl_q;
      end
    end
  end

  generate
    if (HAS_PP) begin : g_pp
      logic [1:0] pp_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pp_q <= 2'b00;
        else if (wr_cause_i && clic_i) pp_q <= wdata_i[29:28];
      end
      assign pp_o = pp_q;
    end else begin : g_no_pp
      assign pp_o = 2'b00;
    end
  endgenerate

  assign tvt_o  = {tvt_q, 6'b0};
  assign thr_o  = thr_q;
  assign act_o  = act_q;
  assign plvl_o = plvl_q;
  assign pie_o  = pie_q;
  assign intr_o = intr_q;
  assign code_o = code_q;

  assert_thr_fill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_thr_i |=> ((thr_o & THR_ONES) == THR_ONES));

  assert_pl_fill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cause_i && clic_i && !enter_i) |=> ((plvl_o & PL_ONES) == PL_ONES));

  assert_legacy_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cause_i && !clic_i && !enter_i) |=> ($stable(plvl_o) && $stable(pie_o) && $stable(pp_o)));

  assert_enter_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_i |=> (plvl_o == $past(act_o)));

  assert_exit_restore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_i && !enter_i) |=> (act_o == $past(plvl_o)));
endmodule

// File: rtl/irq_lvl_csr.sv
module irq_lvl_csr
  import irq_lvl_pkg::*;
#(
  parameter int CTL_BITS = 4,
  parameter int CODE_W   = 5,
  parameter bit USER_EN  = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        csr_re_i,
  input  logic        csr_we_i,
  input  logic [11:0] csr_addr_i,
  input  logic [31:0] csr_wdata_i,
  output logic [31:0] csr_rdata_o,
  output logic        csr_illegal_o,
  input  logic [1:0]  tvec_mode_i,
  input  logic        lvl_enter_i,
  input  logic        lvl_exit_i,
  input  logic        lvl_user_i,
  input  logic [7:0]  lvl_new_i,
  output logic        mpie_o,
  output logic [1:0]  mpp_o,
  output logic        upie_o
);
  dec_t dec;
  logic clic;

  logic [31:0]       tvt_w  [2];
  logic [7:0]        thr_w  [2];
  logic [7:0]        act_w  [2];
  logic [7:0]        plvl_w [2];
  logic              pie_w  [2];
  logic [1:0]        pp_w   [2];
  logic              intr_w [2];
  logic [CODE_W-1:0] code_w [2];

  irq_lvl_dec #(.USER_EN(USER_EN)) u_dec (
    .addr_i (csr_addr_i),
    .dec_o  (dec)
  );

  assign clic = (tvec_mode_i == 2'b11);

  // index 1: machine copy, index 0: user copy
  generate
    for (genvar p = 0; p < 2; p++) begin : g_copy
      if (p == 1 || USER_EN) begin : g_bank
        logic sel_w, sel_e;
        assign sel_w = csr_we_i && (dec.mcopy == (p == 1));
        assign sel_e = (lvl_user_i == (p == 0));
        irq_lvl_bank #(
          .CTL_BITS (CTL_BITS),
          .CODE_W   (CODE_W),
          .HAS_PP   (p == 1)
        ) u_bank (
          .clk_i       (clk_i),
          .rst_ni      (rst_ni),
          .clic_i      (clic),
          .wr_tvt_i    (sel_w && dec.fn == FN_TVT),
          .wr_cause_i  (sel_w && dec.fn == FN_CAUSE),
          .wr_thr_i    (sel_w && dec.fn == FN_THR),
          .wdata_i     (csr_wdata_i),
          .enter_i     (lvl_enter_i && sel_e),
          .exit_i      (lvl_exit_i && sel_e),
          .enter_lvl_i (lvl_new_i),
          .tvt_o       (tvt_w[p]),
          .thr_o       (thr_w[p]),
          .act_o       (act_w[p]),
          .plvl_o      (plvl_w[p]),
          .pie_o       (pie_w[p]),
          .pp_o        (pp_w[p]),
          .intr_o      (intr_w[p]),
          .code_o      (code_w[p])
        );
      end else begin : g_tie
        assign tvt_w[p]  = '0;
        assign thr_w[p]  = '0;
        assign act_w[p]  = '0;
        assign plvl_w[p] = '0;
        assign pie_w[p]  = 1'b0;
        assign pp_w[p]   = 2'b00;
        assign intr_w[p] = 1'b0;
        assign code_w[p] = '0;
      end
    end
  endgenerate

  always_comb begin
    logic s;
    s = dec.mcopy;
    csr_rdata_o = '0;
    case (dec.fn)
      FN_TVT:  csr_rdata_o = tvt_w[s];
      FN_THR:  csr_rdata_o = {24'b0, thr_w[s]};
      FN_STAT: csr_rdata_o = {(s ? act_w[1] : 8'h00), 16'b0, act_w[0]};
      FN_CAUSE: begin
        if (clic)
          csr_rdata_o = {intr_w[s], 1'b0, pp_w[s], pie_w[s], 3'b0, plvl_w[s],
                         {(16-CODE_W){1'b0}}, code_w[s]};
        else
          csr_rdata_o = {intr_w[s], {(31-CODE_W){1'b0}}, code_w[s]};
      end
      default: csr_rdata_o = '0;
    endcase
  end

  assign csr_illegal_o = (csr_re_i || csr_we_i) && (dec.fn == FN_NONE);
  assign mpie_o = pie_w[1];
  assign mpp_o  = pp_w[1];
  assign upie_o = pie_w[0];

  assert_tvt_align_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_re_i && dec.fn == FN_TVT) |-> (csr_rdata_o[5:0] == 6'b0));

  assert_illegal_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |-> (csr_rdata_o == 32'b0));

  assert_stat_ro_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && dec.fn == FN_STAT && !lvl_enter_i && !lvl_exit_i)
      |=> ($stable(act_w[1]) && $stable(act_w[0])));

  assert_pp_user_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_re_i && dec.fn == FN_CAUSE && !dec.mcopy) |-> (csr_rdata_o[29:28] == 2'b00));
endmodule

// File: tb/irq_lvl_csr_tb.sv
module irq_lvl_csr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        re = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        illegal;
  logic [1:0]  mode = 2'b00;
  logic        ent = 1'b0, ext = 1'b0, usr = 1'b0;
  logic [7:0]  lvl = '0;
  logic        mpie, upie;
  logic [1:0]  mpp;

  int checks = 0, errors = 0;

  // reference state, index 1 machine, 0 user
  logic [31:0] r_tvt [2];
  logic [7:0]  r_thr [2], r_act [2], r_pl [2];
  logic        r_pie [2], r_intr [2];
  logic [4:0]  r_code [2];
  logic [1:0]  r_pp;

  always #10 clk = ~clk;

  irq_lvl_csr u_dut (
    .clk_i(clk), .rst_ni(rst_n), .csr_re_i(re), .csr_we_i(we),
    .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
    .csr_illegal_o(illegal), .tvec_mode_i(mode), .lvl_enter_i(ent),
    .lvl_exit_i(ext), .lvl_user_i(usr), .lvl_new_i(lvl),
    .mpie_o(mpie), .mpp_o(mpp), .upie_o(upie)
  );

  // 0 none, 1 base, 2 cause, 3 threshold, 4 status
  function automatic int kind(logic [11:0] a);
    if (a[9:8] != 2'b11 && a[9:8] != 2'b00) return 0;
    case ({a[11:10], a[7:0]})
      10'h007: return 1;
      10'h042: return 2;
      10'h047: return 3;
      10'h3B1: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] ref_read(logic [11:0] a, logic [1:0] md);
    int i;
    i = (a[9:8] == 2'b11) ? 1 : 0;
    case (kind(a))
      1: return r_tvt[i];
      2: if (md == 2'b11)
           return {r_intr[i], 1'b0, (i == 1 ? r_pp : 2'b00), r_pie[i], 3'b0, r_pl[i], 11'b0, r_code[i]};
         else
           return {r_intr[i], 26'b0, r_code[i]};
      3: return {24'b0, r_thr[i]};
      4: return {(i == 1 ? r_act[1] : 8'h00), 16'b0, r_act[0]};
      default: return 32'b0;
    endcase
  endfunction

  function automatic string tag_of(logic [11:0] a, logic [1:0] md);
    case (kind(a))
      1: return "R1";
      2: return (md == 2'b11) ? "R6" : "R5";
      3: return "R4";
      4: return "R2";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string tg, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tg, got, exp);
    end
  endtask

  task automatic ref_reset();
    for (int i = 0; i < 2; i++) begin
      r_tvt[i] = '0; r_thr[i] = 8'h0F; r_act[i] = 8'h0F; r_pl[i] = 8'h0F;
      r_pie[i] = 1'b0; r_intr[i] = 1'b0; r_code[i] = '0;
    end
    r_pp = 2'b00;
  endtask

  task automatic ref_clock(logic w, logic [11:0] a, logic [31:0] d, logic [1:0] md,
                           logic en, logic ex, logic us, logic [7:0] lv);
    logic [7:0] old_act [2];
    logic [7:0] old_pl [2];
    int i, p;
    for (int k = 0; k < 2; k++) begin old_act[k] = r_act[k]; old_pl[k] = r_pl[k]; end
    i = (a[9:8] == 2'b11) ? 1 : 0;
    p = us ? 0 : 1;
    if (w) begin
      case (kind(a))
        1: r_tvt[i] = d & 32'hFFFF_FFC0;
        2: begin
          r_intr[i] = d[31]; r_code[i] = d[4:0];
          if (md == 2'b11) begin
            r_pl[i] = d[23:16] | 8'h0F; r_pie[i] = d[27];
            if (i == 1) r_pp = d[29:28];
          end
        end
        3: r_thr[i] = d[7:0] | 8'h0F;
        default: ;
      endcase
    end
    if (en) begin
      r_pl[p] = old_act[p]; r_act[p] = lv | 8'h0F;
    end else if (ex) begin
      r_act[p] = old_pl[p];
    end
  endtask

  task automatic step(logic r, logic w, logic [11:0] a, logic [31:0] d, logic [1:0] md,
                      logic en, logic ex, logic us, logic [7:0] lv, string tg);
    @(negedge clk);
    chk("R11 mpie", {31'b0, mpie}, {31'b0, r_pie[1]});
    chk("R11 mpp", {30'b0, mpp}, {30'b0, r_pp});
    chk("R11 upie", {31'b0, upie}, {31'b0, r_pie[0]});
    re = r; we = w; addr = a; wdata = d; mode = md;
    ent = en; ext = ex; usr = us; lvl = lv;
    #1;
    if (r || w) chk({tg, " illegal"}, {31'b0, illegal}, {31'b0, (kind(a) == 0)});
    if (r) chk({tg, " rdata"}, rdata, ref_read(a, md));
    @(posedge clk);
    ref_clock(w, a, d, md, en, ex, us, lv);
  endtask

  task automatic rd(logic [11:0] a, logic [1:0] md, string tg);
    step(1'b1, 1'b0, a, 32'h0, md, 1'b0, 1'b0, 1'b0, 8'h0, tg);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [1:0] md, string tg);
    step(1'b0, 1'b1, a, d, md, 1'b0, 1'b0, 1'b0, 8'h0, tg);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] pool [10];
    pool = '{12'h307, 12'h007, 12'h342, 12'h042, 12'h347, 12'h047,
             12'hFB1, 12'hCB1, 12'h300, 12'h107};
    ref_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R3 reset values
    rd(12'h347, 2'b11, "R3");
    rd(12'h047, 2'b11, "R3");
    rd(12'hFB1, 2'b11, "R3");
    rd(12'h342, 2'b11, "R3");
    // R1 alignment
    wr(12'h307, 32'hFFFF_FFFF, 2'b00, "R1");
    rd(12'h307, 2'b00, "R1");
    // R2 status ignores writes
    wr(12'hFB1, 32'h1234_5678, 2'b11, "R2");
    rd(12'hFB1, 2'b11, "R2");
    rd(12'hCB1, 2'b11, "R2");
    // R4 threshold fill
    wr(12'h347, 32'h1234_5620, 2'b11, "R4");
    rd(12'h347, 2'b11, "R4");
    // R6 / R7 controller-mode cause layout and fill
    wr(12'h342, 32'hB8A0_0013, 2'b11, "R6");
    rd(12'h342, 2'b11, "R7");
    // R5 legacy layout and protected fields
    rd(12'h342, 2'b01, "R5");
    wr(12'h342, 32'h0000_0004, 2'b00, "R5");
    rd(12'h342, 2'b11, "R5");
    // R9 entry and return
    step(1'b0, 1'b0, 12'h0, 32'h0, 2'b11, 1'b1, 1'b0, 1'b0, 8'h50, "R9");
    rd(12'hFB1, 2'b11, "R9");
    rd(12'h342, 2'b11, "R9");
    step(1'b0, 1'b0, 12'h0, 32'h0, 2'b11, 1'b0, 1'b1, 1'b0, 8'h00, "R9");
    rd(12'hFB1, 2'b11, "R9");
    // R10 entry collides with cause write
    step(1'b0, 1'b1, 12'h342, 32'h0830_0001, 2'b11, 1'b1, 1'b0, 1'b0, 8'h70, "R10");
    rd(12'h342, 2'b11, "R10");
    step(1'b0, 1'b1, 12'h042, 32'h08C0_0002, 2'b11, 1'b1, 1'b0, 1'b1, 8'h30, "R10");
    rd(12'h042, 2'b11, "R10");
    // R8 selection and illegal addresses
    wr(12'h300, 32'hFFFF_FFFF, 2'b11, "R8");
    rd(12'h300, 2'b11, "R8");
    rd(12'h107, 2'b11, "R8");
    wr(12'h047, 32'h0000_00A0, 2'b11, "R8");
    rd(12'h047, 2'b11, "R8");
    rd(12'h347, 2'b11, "R8");

    // mixed traffic, compared every cycle
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] a;
      logic [1:0]  md;
      logic [31:0] rn;
      rn = $urandom;
      a  = pool[rn[3:0] % 10];
      md = rn[5] ? 2'b11 : rn[7:6];
      step(rn[8], rn[9] & ~rn[8], a, $urandom, md,
           (rn[12:10] == 3'b000), (rn[12:10] == 3'b001), rn[13], rn[23:16],
           tag_of(a, md));
    end

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule